// File: doc/BRIEF.md
# Staged reset sequencer

This block is the reset controller of a small processor subsystem. Three internal causes can start a system reset: a watchdog counter that runs out, a low-supply indication, and an illegal-opcode indication from the instruction decoder. A STOP indication counts as illegal when the stop-enable option bit is 0. The block also contains the watchdog counter itself. Software keeps that counter from running out by writing to one fixed bus address, and the value written does not matter.

Reset is released in stages. After a low-supply event, the module clocks stay gated off while the supply is low. They then stay off for a stabilization hold that starts once the supply is back above the upper trip point. The external reset pin is freed later than the clocks, and the CPU reset is freed after the pin. The CPU then starts its reset-vector fetch. Watchdog and illegal-opcode resets leave the clocks running and go through only the pin and CPU delays.

A small status register records the cause of the latest reset. Reading it clears it. The supply is reported by two level inputs, one for each trip point. Each passes through a two-flop synchronizer, and the two trip points give hysteresis.

Top module: `rst_seq_top`

## Requirements
- R1: With the CPU running, the watchdog counter starts from 0 and advances once per cycle. On the cycle it reaches 2^WDOG_W-1 (1023 by default), the next edge asserts the CPU reset and makes the status value 3'b001 (bit 0 = watchdog cause).
- R2: A bus write strobe whose address equals CLR_ADDR (default 0xFFFF) clears the watchdog counter at the next edge. A write to any other address leaves the counter running.
- R3: The low-supply condition starts when the synchronized under-lower-trip input is 1. This input is seen two edges after it changes. Once started, the hold lasts as long as the synchronized under-upper-trip input stays 1, even after the lower-trip input has returned to 0.
- R4: The module clock enable is 0 during reset, during the low-supply condition, and for STAB_CYC (4096) cycles after the synchronized under-upper-trip input falls. The enable returns 3 + STAB_CYC edges after the upper-trip input is driven low.
- R5: The external reset pin output is low while the clock enable is 0. It rises PIN_DLY (32) cycles after the clock enable returns.
- R6: The CPU reset output rises CPU_DLY (64) cycles after the stabilization hold ends. After reset is released from a supply that is already good, this is 1 + STAB_CYC + CPU_DLY edges. For a watchdog or illegal-opcode reset, the stabilization hold is skipped and the CPU reset rises CPU_DLY edges after it was asserted.
- R7: The status register holds at most one set bit. A strobe on the read input clears it at the next edge. A new reset cause clears the other bits and sets its own bit.
- R8: A low-supply condition makes the status value 3'b100 (bit 2 = supply cause) on the next edge.
- R9: With the CPU running, an illegal-opcode pulse resets the CPU at the next edge and sets status 3'b010 (bit 1 = illegal cause). A STOP pulse does the same when the stop-enable input is 0. When stop-enable is 1, a STOP pulse has no effect.
- R10: A new low-supply event during any stage restarts the sequence from the low-supply hold. The watchdog counter is held at 0 whenever the CPU reset is asserted.
- R11: Causes take priority in the order supply, then watchdog, then illegal opcode. Illegal-opcode and STOP indications are ignored while the CPU reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vdd_under_lo_i | input | 1 | Supply is below the lower (falling) trip point |
| vdd_under_hi_i | input | 1 | Supply is below the upper (rising) trip point |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus write address |
| illegal_op_i | input | 1 | Illegal-opcode pulse from the decoder |
| stop_op_i | input | 1 | STOP instruction pulse from the decoder |
| stop_en_i | input | 1 | Stop-enable option bit |
| stat_rd_i | input | 1 | Status read strobe; clears the status register |
| stat_o | output | 3 | Reset cause status: bit 2 supply, bit 1 illegal, bit 0 watchdog |
| mod_clk_en_o | output | 1 | CPU and module clock enable |
| rst_pin_no | output | 1 | External reset pin drive, active low |
| cpu_rst_no | output | 1 | CPU reset, active low |

## Verification
The assertions check on every cycle the order in which reset is released: the pin is never free while the clocks are gated, the CPU is never free while the pin is low, and the watchdog is zero under reset. They also check that a clearing write resets the counter, that each cause produces its one status bit, and that a read empties the register. The exact cycle counts of the stabilization hold and the two release delays can only be seen in the bench scenarios. The same holds for the hysteresis gap between the trip points, for a supply drop part-way through the sequence, and for a watchdog overflow that coincides with an illegal opcode.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LOW  = 2'd1,
    ST_STAB = 2'd2,
    ST_POST = 2'd3
  } seq_st_e;

  localparam int CAUSE_W = 3;
  localparam int CB_COP  = 0;
  localparam int CB_ILOP = 1;
  localparam int CB_LVI  = 2;
endpackage

// File: rtl/rst_seq_sync.sv
`timescale 1ns/1ps
module rst_seq_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rst_seq_wdog.sv
`timescale 1ns/1ps
module rst_seq_wdog #(
  parameter int              CNT_W    = 10,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CLR_ADDR = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ovf_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             clr;

  assign clr = wr_i && (addr_i == CLR_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || clr) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = run_i && !clr && (cnt_q == CNT_MAX);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rst_seq_fsm.sv
`timescale 1ns/1ps
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYC = 4096,
  parameter int PIN_DLY  = 32,
  parameter int CPU_DLY  = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lv_s_i,
  input  logic               under_hi_s_i,
  input  logic               wd_ovf_i,
  input  logic               ilop_i,
  input  logic               stat_rd_i,
  output logic               clk_en_o,
  output logic               pin_rel_o,
  output logic               cpu_rel_o,
  output logic [CAUSE_W-1:0] stat_o
);
  localparam int MAXC  = (STAB_CYC > CPU_DLY) ? STAB_CYC : CPU_DLY;
  localparam int SEQ_W = $clog2(MAXC);
  localparam logic [SEQ_W-1:0] STAB_LAST = SEQ_W'(STAB_CYC - 1);
  localparam logic [SEQ_W-1:0] CPU_LAST  = SEQ_W'(CPU_DLY - 1);
  localparam logic [SEQ_W-1:0] PIN_AT    = SEQ_W'(PIN_DLY);

  seq_st_e            st_q, st_d;
  logic [SEQ_W-1:0]   cnt_q, cnt_d;
  logic [CAUSE_W-1:0] stat_q, stat_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    stat_d = stat_q;
    if (stat_rd_i) stat_d = '0;
    if (lv_s_i) begin
      // supply drop wins in every stage and restarts the sequence
      st_d           = ST_LOW;
      cnt_d          = '0;
      stat_d         = '0;
      stat_d[CB_LVI] = 1'b1;
    end else begin
      unique case (st_q)
        ST_LOW: begin
          if (!under_hi_s_i) begin
            st_d  = ST_STAB;
            cnt_d = '0;
          end
        end
        ST_STAB: begin
          if (cnt_q == STAB_LAST) begin
            st_d  = ST_POST;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_POST: begin
          if (cnt_q == CPU_LAST) begin
            st_d  = ST_RUN;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_RUN: begin
          if (wd_ovf_i) begin
            st_d           = ST_POST;
            cnt_d          = '0;
            stat_d         = '0;
            stat_d[CB_COP] = 1'b1;
          end else if (ilop_i) begin
            st_d            = ST_POST;
            cnt_d           = '0;
            stat_d          = '0;
            stat_d[CB_ILOP] = 1'b1;
          end
        end
        default: st_d = ST_LOW;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LOW;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
    end
  end

  assign clk_en_o  = (st_q == ST_RUN) || (st_q == ST_POST);
  assign pin_rel_o = (st_q == ST_RUN) || ((st_q == ST_POST) && (cnt_q >= PIN_AT));
  assign cpu_rel_o = (st_q == ST_RUN);
  assign stat_o    = stat_q;
endmodule

// File: rtl/rst_seq_top.sv
`timescale 1ns/1ps
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int                STAB_CYC = 4096,
  parameter int                PIN_DLY  = 32,
  parameter int                CPU_DLY  = 64,
  parameter int                WDOG_W   = 10,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CLR_ADDR = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vdd_under_lo_i,
  input  logic              vdd_under_hi_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              illegal_op_i,
  input  logic              stop_op_i,
  input  logic              stop_en_i,
  input  logic              stat_rd_i,
  output logic [2:0]        stat_o,
  output logic              mod_clk_en_o,
  output logic              rst_pin_no,
  output logic              cpu_rst_no
);
  logic [1:0]        sup_s;
  logic              lv_s, under_hi_s;
  logic              wd_ovf, ilop_req, cpu_rel;
  logic [WDOG_W-1:0] wd_cnt;

  rst_seq_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vdd_under_hi_i, vdd_under_lo_i}),
    .q_o   (sup_s)
  );

  assign lv_s       = sup_s[0];
  assign under_hi_s = sup_s[1];
  assign ilop_req   = illegal_op_i || (stop_op_i && !stop_en_i);

  rst_seq_wdog #(
    .CNT_W   (WDOG_W),
    .ADDR_W  (ADDR_W),
    .CLR_ADDR(CLR_ADDR)
  ) u_wdog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (cpu_rel),
    .wr_i  (bus_wr_i),
    .addr_i(bus_addr_i),
    .ovf_o (wd_ovf),
    .cnt_o (wd_cnt)
  );

  rst_seq_fsm #(
    .STAB_CYC(STAB_CYC),
    .PIN_DLY (PIN_DLY),
    .CPU_DLY (CPU_DLY)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lv_s_i      (lv_s),
    .under_hi_s_i(under_hi_s),
    .wd_ovf_i    (wd_ovf),
    .ilop_i      (ilop_req),
    .stat_rd_i   (stat_rd_i),
    .clk_en_o    (mod_clk_en_o),
    .pin_rel_o   (rst_pin_no),
    .cpu_rel_o   (cpu_rel),
    .stat_o      (stat_o)
  );

  assign cpu_rst_no = cpu_rel;
endmodule

// File: rtl/rst_seq_chk.sv
`timescale 1ns/1ps
module rst_seq_chk #(
  parameter int                WDOG_W   = 10,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CLR_ADDR = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lv_s,
  input logic              wd_ovf,
  input logic [WDOG_W-1:0] wd_cnt,
  input logic              stat_rd_i,
  input logic [2:0]        stat_o,
  input logic              mod_clk_en_o,
  input logic              rst_pin_no,
  input logic              cpu_rst_no,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              stop_op_i,
  input logic              stop_en_i
);
  assert_cop_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_ovf && !lv_s |=> (stat_o == 3'b001) && !cpu_rst_no);

  assert_kick_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && (bus_addr_i == CLR_ADDR) |=> (wd_cnt == '0));

  assert_pin_low_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_clk_en_o |-> !rst_pin_no);

  assert_pin_rise_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pin_no) |-> mod_clk_en_o && !cpu_rst_no);

  assert_cpu_after_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_no |-> rst_pin_no && mod_clk_en_o);

  assert_stat_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_o));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !lv_s && !cpu_rst_no |=> (stat_o == 3'b000));

  assert_lvi_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lv_s |=> (stat_o == 3'b100) && !mod_clk_en_o);

  assert_stop_illegal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_no && stop_op_i && !stop_en_i && !wd_ovf && !lv_s |=> (stat_o == 3'b010));

  assert_wdog_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rst_no |=> (wd_cnt == '0));
endmodule

bind rst_seq_top rst_seq_chk #(
  .WDOG_W  (WDOG_W),
  .ADDR_W  (ADDR_W),
  .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lv_s        (lv_s),
  .wd_ovf      (wd_ovf),
  .wd_cnt      (wd_cnt),
  .stat_rd_i   (stat_rd_i),
  .stat_o      (stat_o),
  .mod_clk_en_o(mod_clk_en_o),
  .rst_pin_no  (rst_pin_no),
  .cpu_rst_no  (cpu_rst_no),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .stop_op_i   (stop_op_i),
  .stop_en_i   (stop_en_i)
);

// File: tb/rst_seq_top_tb_top.sv
`timescale 1ns/1ps
module rst_seq_top_tb_top;
  localparam int WD_MAX = 1023;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        under_lo, under_hi, wr, illegal, stop_op, stop_en, stat_rd;
  logic [15:0] addr;
  logic [2:0]  stat;
  logic        clk_en, pin_n, cpu_n;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  rst_seq_top dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .vdd_under_lo_i(under_lo),
    .vdd_under_hi_i(under_hi),
    .bus_wr_i      (wr),
    .bus_addr_i    (addr),
    .illegal_op_i  (illegal),
    .stop_op_i     (stop_op),
    .stop_en_i     (stop_en),
    .stat_rd_i     (stat_rd),
    .stat_o        (stat),
    .mod_clk_en_o  (clk_en),
    .rst_pin_no    (pin_n),
    .cpu_rst_no    (cpu_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: mode 0 run, 1 supply low, 2 stabilize, 3 release stages
  int       md, mc, wd;
  bit [2:0] ms;
  bit       s1l, s2l, s1h, s2h;

  always @(posedge clk) begin : ref_model
    bit clr, ovf, il;
    int old_md;
    if (!rst_n) begin
      md = 1; mc = 0; wd = 0; ms = 3'b000;
      s1l = 0; s2l = 0; s1h = 0; s2h = 0;
    end else begin
      clr    = wr && (addr == 16'hFFFF);
      ovf    = (md == 0) && !clr && (wd == WD_MAX);
      il     = illegal || (stop_op && !stop_en);
      old_md = md;
      if (stat_rd) ms = 3'b000;
      if (s2l) begin
        md = 1; mc = 0; ms = 3'b100;
      end else if (md == 1) begin
        if (!s2h) begin md = 2; mc = 0; end
      end else if (md == 2) begin
        if (mc == 4095) begin md = 3; mc = 0; end else mc++;
      end else if (md == 3) begin
        if (mc == 63) begin md = 0; mc = 0; end else mc++;
      end else begin
        if (ovf)     begin md = 3; mc = 0; ms = 3'b001; end
        else if (il) begin md = 3; mc = 0; ms = 3'b010; end
      end
      wd  = (old_md != 0 || clr) ? 0 : wd + 1;
      s2l = s1l; s1l = under_lo;
      s2h = s1h; s1h = under_hi;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(clk_en == (md == 0 || md == 3), "R4 clock enable vs model", int'(clk_en), int'(md == 0 || md == 3));
      chk(pin_n == (md == 0 || (md == 3 && mc >= 32)), "R5 reset pin vs model", int'(pin_n),
          int'(md == 0 || (md == 3 && mc >= 32)));
      chk(cpu_n == (md == 0), "R6 cpu reset vs model", int'(cpu_n), int'(md == 0));
      chk(stat == ms, "R7 status vs model", int'(stat), int'(ms));
    end
  end

  function automatic int sig(input int sel);
    case (sel)
      0:       return int'(clk_en);
      1:       return int'(pin_n);
      default: return int'(cpu_n);
    endcase
  endfunction

  task automatic wait_val(input int sel, input int val, output int n);
    n = 0;
    while (sig(sel) != val && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a);
    wr = 1'b1; addr = a;
    @(negedge clk);
    wr = 1'b0; addr = '0;
  endtask

  task automatic read_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic pulse_ilop();
    illegal = 1'b1;
    @(negedge clk);
    illegal = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_op = 1'b1;
    @(negedge clk);
    stop_op = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog timeout, requirement R6 sequence hung, actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; under_lo = 0; under_hi = 0; wr = 0; addr = '0;
    illegal = 0; stop_op = 0; stop_en = 0; stat_rd = 0;
    cyc(3);
    chk(!clk_en && !pin_n && !cpu_n, "R6 reset state outputs", int'({clk_en, pin_n, cpu_n}), 0);
    chk(stat == 3'b000, "R7 reset state status", int'(stat), 0);

    rst_n = 1'b1;
    wait_val(2, 1, n);
    chk(n == 4161, "R6 power-up release delay", n, 4161);

    // watchdog runs out
    wait_val(2, 0, n);
    chk(n == 1024, "R1 watchdog overflow time", n, 1024);
    chk(stat == 3'b001, "R1 watchdog cause", int'(stat), 1);
    wait_val(2, 1, n);
    chk(n == 64, "R6 internal reset release delay", n, 64);
    read_stat();
    chk(stat == 3'b000, "R7 read clears status", int'(stat), 0);

    // regular clearing writes keep the CPU running
    for (int i = 0; i < 6; i++) begin
      bus_write(16'hFFFF);
      cyc(600);
    end
    chk(cpu_n == 1'b1, "R2 clearing writes prevent overflow", int'(cpu_n), 1);
    bus_write(16'hFFFE);
    wait_val(2, 0, n);
    chk(n == 423, "R2 other address does not clear", n, 423);
    wait_val(2, 1, n);
    read_stat();

    // illegal opcode and STOP handling
    pulse_ilop();
    chk(cpu_n == 1'b0 && stat == 3'b010, "R9 illegal opcode cause", int'(stat), 2);
    wait_val(2, 1, n);
    read_stat();
    stop_en = 1'b1;
    pulse_stop();
    chk(cpu_n == 1'b1 && stat == 3'b000, "R9 STOP ignored when enabled", int'({cpu_n, stat}), 8);
    stop_en = 1'b0;
    pulse_stop();
    chk(cpu_n == 1'b0 && stat == 3'b010, "R9 STOP illegal when disabled", int'(stat), 2);
    wait_val(2, 1, n);
    read_stat();

    // illegal indication ignored while held
    pulse_ilop();
    cyc(5);
    read_stat();
    pulse_ilop();
    wait_val(2, 1, n);
    chk(stat == 3'b000, "R11 illegal ignored during hold", int'(stat), 0);

    // watchdog wins over illegal opcode in the same cycle
    cyc(1023);
    pulse_ilop();
    chk(stat == 3'b001 && cpu_n == 1'b0, "R11 watchdog over illegal", int'(stat), 1);
    wait_val(2, 1, n);
    read_stat();

    // low supply with hysteresis
    under_lo = 1'b1; under_hi = 1'b1;
    cyc(5);
    chk(!clk_en && !pin_n && !cpu_n, "R4 supply low gates clocks", int'({clk_en, pin_n, cpu_n}), 0);
    chk(stat == 3'b100, "R8 supply cause", int'(stat), 4);
    under_lo = 1'b0;
    cyc(40);
    chk(clk_en == 1'b0, "R3 hold while under upper trip", int'(clk_en), 0);
    under_hi = 1'b0;
    wait_val(0, 1, n);
    chk(n == 4099, "R4 stabilization hold length", n, 4099);
    wait_val(1, 1, n);
    chk(n == 32, "R5 pin release after hold", n, 32);
    wait_val(2, 1, n);
    chk(n == 32, "R6 cpu release after pin", n, 32);
    read_stat();

    // supply drop during the release stages restarts the sequence
    under_hi = 1'b1; under_lo = 1'b1;
    cyc(3);
    under_lo = 1'b0; under_hi = 1'b0;
    wait_val(0, 1, n);
    cyc(10);
    under_lo = 1'b1; under_hi = 1'b1;
    cyc(3);
    chk(clk_en == 1'b0, "R10 restart on drop in release stage", int'(clk_en), 0);
    under_lo = 1'b0; under_hi = 1'b0;
    wait_val(2, 1, n);
    chk(n == 4163, "R10 full sequence after restart", n, 4163);
    chk(stat == 3'b100, "R8 supply cause after restart", int'(stat), 4);

    cyc(4);
    finish_run();
  end
endmodule